// File: doc/BRIEF.md
# PC Card Socket Status Controller

This block is the host-facing register set of a PC card adapter that serves four sockets: two controller instances, each with two sockets, share one index space. The host sees only two byte locations. A write to the index location selects a register. Reads and writes to the data location then reach that register. Each socket has the following registers:

- a fixed identification byte
- a live interface status byte built from the socket pins
- power control, general control and window-enable bytes that the host can read and write
- a latched status-change byte
- a change-interrupt configuration byte

The raw socket pins are asynchronous. These are the two card-detect lines, the two battery-sense lines, write protect, ready and power good. Each goes through a synchronizer before the block uses it. Card insertion, card removal and battery degradation set event bits that stay latched until the host reads them. The enabled events of a socket drive one of sixteen interrupt lines. The socket's own configuration selects which line.

Top module: `pcs_ctl`

## Requirements
- R1: A write to the index location (bus_sel=0) stores the index. Later data-location accesses (bus_sel=1) read or write the register that the index selects. Power control (offset 0x02), general control (0x03), change configuration (0x05) and window enable (0x06) read back the last byte written to them.
- R2: Index bits 7:6 pick one of four socket register sets, with bit 7 as the controller and bit 6 as the socket. Bits 5:0 pick the register offset. A write to one socket leaves the registers of the other sockets unchanged.
- R3: Offset 0x00 always reads {4'h8, REV}, where REV is a nonzero parameter. Writes to it have no effect.
- R4: Offset 0x01 reads the synchronized pins as follows: bits 3:2 hold card_det, bits 1:0 hold bat_sense, bit 4 holds write protect, bit 5 holds ready, and bit 7 is 0.
- R5: Status bit 6 (powered) is 1 only when pwr_good is high and power control bit 4 (card enable) is set.
- R6: Reset clears every writable register and every latched event to zero, and leaves all irq_lines low.
- R7: A card counts as present only when both card_det bits are 1. Each change between present and absent sets bit 3 of the change register (offset 0x04) once. A detect-line change that leaves presence the same sets nothing.
- R8: Battery sense 2'b01 means warning and any value with bit 0 clear means dead. Entering the warning state sets change bit 1, and entering the dead state sets change bit 0.
- R9: A data read of the change register returns the latched events and then clears them, so an immediate second read returns 0.
- R10: irq_lines[N] is high, where N is configuration bits 7:4, while any latched event has its enable set in configuration bit 3 (detect), bit 1 (warning) or bit 0 (dead). A masked event stays latched but raises no line.
- R11: Offsets 0x07 to 0x3F read 0, and writes to them have no effect.
- R12: When several sockets are pending on the same interrupt number, the line stays high until the last of those sockets has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | 0 selects the index location, 1 selects the data location |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; read data is valid in the same cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register the index selects |
| card_det | input | 8 | Two card-detect lines per socket, socket s at bits 2s+1:2s |
| bat_sense | input | 8 | Two battery-sense lines per socket, socket s at bits 2s+1:2s |
| wr_prot | input | 4 | Write-protect pin per socket |
| card_rdy | input | 4 | Ready pin per socket |
| pwr_good | input | 4 | Socket supply good per socket |
| irq_lines | output | 16 | Management interrupt lines, one per interrupt number |

## Verification
The bench builds the block with REV=5 and SYNC_STAGES=3, so the identification byte must read 0x85. A pin change then takes four clock edges before it latches, which shows any check that samples too early. With all four sockets in use, the bench can check that a write to one socket does not reach its neighbours. It can also point two sockets at the same interrupt number and watch the line stay up until the second socket is cleared. The bench drives battery sense through good, warning and dead, and drives detect transitions that keep presence unchanged. This shows that each event latches exactly once and that a masked event stays latched but raises no line.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int SOCK_W = 2;
    localparam int NSOCK  = 2 ** SOCK_W;
    localparam int IRQ_W  = 4;
    localparam int IRQ_N  = 2 ** IRQ_W;
    localparam int OFS_W  = 6;

    typedef enum logic [OFS_W-1:0] {
        OFS_IDENT  = 6'h00,
        OFS_STAT   = 6'h01,
        OFS_PWR    = 6'h02,
        OFS_GCTL   = 6'h03,
        OFS_CHG    = 6'h04,
        OFS_CHGCFG = 6'h05,
        OFS_WIN    = 6'h06
    } reg_ofs_e;

    typedef struct packed {
        logic [1:0] det;
        logic [1:0] bvd;
        logic       wp;
        logic       rdy;
        logic       pgood;
    } pins_t;

    // event vector layout: [2]=detect change, [1]=battery warning, [0]=battery dead
    localparam int EVT_W = 3;

    function automatic logic is_present(input logic [1:0] d);
        return d[1] & d[0];
    endfunction

    function automatic logic is_warn(input logic [1:0] b);
        return (b == 2'b01);
    endfunction

    function automatic logic is_dead(input logic [1:0] b);
        return !b[0];
    endfunction

    function automatic logic [7:0] chg_byte(input logic [EVT_W-1:0] e);
        return {4'b0000, e[2], 1'b0, e[1], e[0]};
    endfunction

    function automatic logic [EVT_W-1:0] cfg_mask(input logic [7:0] c);
        return {c[3], c[1], c[0]};
    endfunction
endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= '0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pcs_socket.sv
module pcs_socket
    import pcs_pkg::*;
#(
    parameter logic [3:0] REV         = 4'h1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  pins_t            pins_raw,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             irq_req,
    output logic [IRQ_W-1:0] irq_num
);
    logic [$bits(pins_t)-1:0] pins_vec;
    pins_t                    pins_s;

    pcs_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_vec)
    );
    assign pins_s = pins_vec;

    logic [1:0] det_prev, bvd_prev;
    logic [EVT_W-1:0] evt, pend_q;
    logic [7:0] pwr_q, gctl_q, cfg_q, win_q;

    always_comb begin
        evt[2] = is_present(pins_s.det) ^ is_present(det_prev);
        evt[1] = is_warn(pins_s.bvd) & !is_warn(bvd_prev);
        evt[0] = is_dead(pins_s.bvd) & !is_dead(bvd_prev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_prev <= '0;
            bvd_prev <= '0;
        end else begin
            det_prev <= pins_s.det;
            bvd_prev <= pins_s.bvd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q  <= '0;
            gctl_q <= '0;
            cfg_q  <= '0;
            win_q  <= '0;
        end else if (wr_en) begin
            case (reg_ofs_e'(ofs))
                OFS_PWR:    pwr_q  <= wdata;
                OFS_GCTL:   gctl_q <= wdata;
                OFS_CHGCFG: cfg_q  <= wdata;
                OFS_WIN:    win_q  <= wdata;
                default:    ;
            endcase
        end
    end

    // read-to-clear; an event arriving in the clearing cycle survives
    always_ff @(posedge clk) begin
        if (rst)                             pend_q <= '0;
        else if (rd_en && ofs == OFS_CHG)    pend_q <= evt;
        else                                 pend_q <= pend_q | evt;
    end

    always_comb begin
        case (reg_ofs_e'(ofs))
            OFS_IDENT:  rdata = {4'h8, REV};
            OFS_STAT:   rdata = {1'b0, pins_s.pgood & pwr_q[4], pins_s.rdy,
                                 pins_s.wp, pins_s.det, pins_s.bvd};
            OFS_PWR:    rdata = pwr_q;
            OFS_GCTL:   rdata = gctl_q;
            OFS_CHG:    rdata = chg_byte(pend_q);
            OFS_CHGCFG: rdata = cfg_q;
            OFS_WIN:    rdata = win_q;
            default:    rdata = 8'h00;
        endcase
    end

    assign irq_req = |(pend_q & cfg_mask(cfg_q));
    assign irq_num = cfg_q[7:4];
endmodule

// File: rtl/pcs_irq_route.sv
module pcs_irq_route #(
    parameter int NSRC  = 4,
    parameter int NUM_W = 4,
    localparam int NLINES = 2 ** NUM_W
) (
    input  logic [NSRC-1:0]            req,
    input  logic [NSRC-1:0][NUM_W-1:0] num,
    output logic [NLINES-1:0]          lines
);
    always_comb begin
        lines = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (req[s]) lines[num[s]] = 1'b1;
        end
    end
endmodule

// File: rtl/pcs_ctl.sv
module pcs_ctl
    import pcs_pkg::*;
#(
    parameter logic [3:0] REV         = 4'h3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic [2*NSOCK-1:0] card_det,
    input  logic [2*NSOCK-1:0] bat_sense,
    input  logic [NSOCK-1:0]   wr_prot,
    input  logic [NSOCK-1:0]   card_rdy,
    input  logic [NSOCK-1:0]   pwr_good,
    output logic [IRQ_N-1:0]   irq_lines
);
    logic [7:0]                    idx_q;
    logic [SOCK_W-1:0]             sock_sel;
    logic [OFS_W-1:0]              ofs;
    logic [7:0]                    sock_rdata [NSOCK];
    logic [NSOCK-1:0]              sock_req;
    logic [NSOCK-1:0][IRQ_W-1:0]   sock_num;

    always_ff @(posedge clk) begin
        if (rst)                     idx_q <= '0;
        else if (bus_wr && !bus_sel) idx_q <= bus_wdata;
    end

    assign sock_sel = idx_q[7:6];
    assign ofs      = idx_q[OFS_W-1:0];

    for (genvar s = 0; s < NSOCK; s++) begin : g_sock
        pins_t raw;
        logic  hit;
        assign raw = {card_det[2*s +: 2], bat_sense[2*s +: 2],
                      wr_prot[s], card_rdy[s], pwr_good[s]};
        assign hit = bus_sel && (sock_sel == SOCK_W'(s));

        pcs_socket #(.REV(REV), .SYNC_STAGES(SYNC_STAGES)) u_sock (
            .clk      (clk),
            .rst      (rst),
            .pins_raw (raw),
            .wr_en    (bus_wr && hit),
            .rd_en    (bus_rd && hit),
            .ofs      (ofs),
            .wdata    (bus_wdata),
            .rdata    (sock_rdata[s]),
            .irq_req  (sock_req[s]),
            .irq_num  (sock_num[s])
        );
    end

    assign bus_rdata = sock_rdata[sock_sel];

    pcs_irq_route #(.NSRC(NSOCK), .NUM_W(IRQ_W)) u_route (
        .req   (sock_req),
        .num   (sock_num),
        .lines (irq_lines)
    );
endmodule

// File: rtl/pcs_ctl_chk.sv
module pcs_ctl_chk
    import pcs_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_sel,
    input logic                     bus_rd,
    input logic [7:0]               idx_q,
    input logic [7:0]               bus_rdata,
    input logic [IRQ_N-1:0]         irq_lines,
    input logic [NSOCK-1:0]         sock_req,
    input logic [NSOCK-1:0][IRQ_W-1:0] sock_num
);
    logic data_rd;
    assign data_rd = bus_rd && bus_sel;

    // R3
    ident_value_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && idx_q[5:0] == 6'h00) |-> (bus_rdata[7:4] == 4'h8 && bus_rdata[3:0] != 4'h0));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && idx_q[5:0] > 6'h06) |-> (bus_rdata == 8'h00));

    // R4
    stat_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && idx_q[5:0] == 6'h01) |-> !bus_rdata[7]);

    // R6
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (irq_lines == '0 && sock_req == '0));

    for (genvar s = 0; s < NSOCK; s++) begin : g_src
        // R10
        req_drives_line_chk: assert property (@(posedge clk) disable iff (rst)
            sock_req[s] |-> irq_lines[sock_num[s]]);
    end

    // R12
    line_has_source_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_lines != '0) |-> (sock_req != '0));
endmodule

bind pcs_ctl pcs_ctl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .idx_q     (idx_q),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .sock_req  (sock_req),
    .sock_num  (sock_num)
);

// File: tb/pcs_ctl_bench.sv
`timescale 1ns/1ps
module pcs_ctl_bench;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  card_det = 8'h00;
    logic [7:0]  bat_sense = 8'hFF;
    logic [3:0]  wr_prot = 4'h0, card_rdy = 4'h0, pwr_good = 4'h0;
    logic [15:0] irq_lines;

    int n_chk = 0;
    int n_err = 0;

    typedef struct { logic [7:0] exp; string req; } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    pcs_ctl #(.REV(4'h5), .SYNC_STAGES(3)) u_pcs_ctl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .card_det(card_det),
        .bat_sense(bat_sense), .wr_prot(wr_prot), .card_rdy(card_rdy),
        .pwr_good(pwr_good), .irq_lines(irq_lines)
    );

    // monitor: compare each data read against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_rd && bus_sel) begin
            sb_item_t it;
            n_chk++;
            if (sb_q.size() == 0) begin
                n_err++;
                $display("FAIL R1: unexpected read rdata=%02h expected none", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: rdata=%02h expected %02h", it.req, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] v);
        @(posedge clk); #1;
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic reg_wr(input int s, input logic [5:0] o, input logic [7:0] v);
        bus_write(1'b0, {s[1:0], o});
        bus_write(1'b1, v);
    endtask

    task automatic reg_rd(input int s, input logic [5:0] o, input logic [7:0] exp, input string req);
        sb_item_t it;
        bus_write(1'b0, {s[1:0], o});
        @(posedge clk); #1;
        it.exp = exp; it.req = req;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(input logic [15:0] exp, input string req);
        @(negedge clk);
        n_chk++;
        if (irq_lines !== exp) begin
            n_err++;
            $display("FAIL %s: irq_lines=%04h expected %04h", req, irq_lines, exp);
        end
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_err++;
        n_chk++;
        $display("FAIL R1: watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        settle(3);
        rst = 1'b0;
        settle(6);

        // R6: reset state
        for (int s = 0; s < NS; s++) begin
            reg_rd(s, 6'h02, 8'h00, "R6 power");
            reg_rd(s, 6'h05, 8'h00, "R6 chgcfg");
            reg_rd(s, 6'h06, 8'h00, "R6 window");
            reg_rd(s, 6'h04, 8'h00, "R6 change");
        end
        reg_rd(0, 6'h03, 8'h00, "R6 gctl");
        chk_irq(16'h0000, "R6 irq");

        // R3: identification, write ignored
        for (int s = 0; s < NS; s++) reg_rd(s, 6'h00, 8'h85, "R3 ident");
        reg_wr(1, 6'h00, 8'h00);
        reg_rd(1, 6'h00, 8'h85, "R3 ident after write");

        // R1 / R2: readback and socket isolation
        reg_wr(1, 6'h02, 8'hB1);
        reg_wr(2, 6'h03, 8'h63);
        reg_wr(3, 6'h06, 8'h41);
        reg_wr(0, 6'h05, 8'h00);
        reg_rd(1, 6'h02, 8'hB1, "R1 power readback");
        reg_rd(2, 6'h03, 8'h63, "R1 gctl readback");
        reg_rd(3, 6'h06, 8'h41, "R1 window readback");
        reg_rd(0, 6'h02, 8'h00, "R2 socket0 power untouched");
        reg_rd(3, 6'h03, 8'h00, "R2 socket3 gctl untouched");
        reg_rd(2, 6'h06, 8'h00, "R2 socket2 window untouched");

        // R11: unmapped offsets
        reg_wr(0, 6'h07, 8'hFF);
        reg_rd(0, 6'h07, 8'h00, "R11 offset 07");
        reg_rd(0, 6'h3F, 8'h00, "R11 offset 3F");
        reg_rd(3, 6'h0A, 8'h00, "R11 offset 0A");

        // R4 / R5 / R7: socket 2 insertion with wp and ready
        card_det[5:4] = 2'b11; wr_prot[2] = 1'b1; card_rdy[2] = 1'b1; pwr_good[2] = 1'b1;
        settle(6);
        reg_rd(2, 6'h01, 8'h3F, "R4 status");
        reg_rd(2, 6'h04, 8'h08, "R7 insertion event");
        reg_rd(2, 6'h04, 8'h00, "R9 cleared by read");
        reg_wr(2, 6'h02, 8'h10);
        reg_rd(2, 6'h01, 8'h7F, "R5 powered");
        pwr_good[2] = 1'b0;
        settle(6);
        reg_rd(2, 6'h01, 8'h3F, "R5 supply lost");

        // R7: partial detect on socket 0
        card_det[1:0] = 2'b01;
        settle(6);
        reg_rd(0, 6'h04, 8'h00, "R7 half detect no event");
        card_det[1:0] = 2'b11;
        settle(6);
        reg_rd(0, 6'h04, 8'h08, "R7 full insertion");
        card_det[1:0] = 2'b10;
        settle(6);
        reg_rd(0, 6'h04, 8'h08, "R7 removal");

        // R8: battery on socket 1
        bat_sense[3:2] = 2'b01;
        settle(6);
        reg_rd(1, 6'h04, 8'h02, "R8 warning");
        bat_sense[3:2] = 2'b00;
        settle(6);
        reg_rd(1, 6'h04, 8'h01, "R8 dead");
        reg_rd(1, 6'h04, 8'h00, "R9 second read");

        // R10: routing and masking on socket 1
        reg_wr(1, 6'h05, 8'hA2);
        bat_sense[3:2] = 2'b11;
        settle(6);
        chk_irq(16'h0000, "R10 idle");
        bat_sense[3:2] = 2'b01;
        settle(6);
        chk_irq(16'h0400, "R10 warning on line 10");
        reg_rd(1, 6'h04, 8'h02, "R10 warning latched");
        chk_irq(16'h0000, "R10 cleared");
        reg_wr(1, 6'h05, 8'hA8);
        bat_sense[3:2] = 2'b00;
        settle(6);
        chk_irq(16'h0000, "R10 masked dead");
        reg_rd(1, 6'h04, 8'h01, "R10 masked still latched");

        // R12: two sockets on line 5
        reg_wr(0, 6'h05, 8'h58);
        reg_wr(3, 6'h05, 8'h58);
        card_det[1:0] = 2'b11;
        card_det[7:6] = 2'b11;
        settle(6);
        chk_irq(16'h0020, "R12 shared line");
        reg_rd(0, 6'h04, 8'h08, "R12 socket0 event");
        chk_irq(16'h0020, "R12 held by socket3");
        reg_rd(3, 6'h04, 8'h08, "R12 socket3 event");
        chk_irq(16'h0000, "R12 released");

        // R6: reset in mid-run
        card_det[7:6] = 2'b00;
        settle(6);
        @(posedge clk); #1; rst = 1'b1;
        settle(2);
        rst = 1'b0;
        settle(6);
        chk_irq(16'h0000, "R6 irq after reset");
        reg_rd(1, 6'h02, 8'h00, "R6 power after reset");
        reg_rd(3, 6'h05, 8'h00, "R6 chgcfg after reset");

        settle(3);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule